// File: doc/BRIEF.md
# Three-Class Channel Pacing Scheduler

This block decides which transmit channel owns each global transmit slot. A small fixed set of channels is kept, eight by default. Each channel carries a class (low-delay, paced or best-effort), a ready level from the queueing logic, a rate parameter and a stored due time. A shared slot clock, called paced-time, runs in 16.8 fixed point. It moves forward by one whole unit only in slots that a paced or best-effort channel wins.

A grant strobe opens a slot. The block then picks one winner by class priority and reports the winner's channel number one cycle later. In the same edge it updates the winner's due time and paced-time. A paced channel's next due time is built from its previous due time, not from the current time. A rate change therefore lands only after the already scheduled due time has been served. A resume pulse pulls the due time back to the present, so the channel can send at the next slot.

Configuration is a single write port that sets the class and rate of one channel. Resume pulses arrive one bit per channel.

Top module: `pacer_sched`

## Requirements
- R1: After reset, outValid is low, paced-time is zero, and every channel is best-effort with rate 1.0 (0x000100) and due time zero. The round-robin search in each class starts at channel 0.
- R2: On a grant, any ready low-delay channel wins over every paced and best-effort channel.
- R3: Within the low-delay class, and within the best-effort class, the winner is the first ready channel after that class's last winner, in rising ID order with wrap-around.
- R4: A paced channel may win only when it is ready and the integer part of its due time is at or before the integer part of paced-time. Among such channels the earliest due time wins, and a tie goes to the lowest ID. A paced channel beats every best-effort channel.
- R5: When a paced channel wins, its due time becomes its previous due time plus its rate parameter, modulo 2^24.
- R6: Writing a new rate leaves the stored due time unchanged. The new rate is first applied when the channel next wins.
- R7: A resume pulse sets that channel's due time to the current paced-time, so a ready paced channel is eligible at the very next grant. Resume overrides a due-time update in the same cycle.
- R8: Paced-time grows by exactly 1.0 (0x000100) on each grant won by a paced or best-effort channel. It holds on low-delay wins and on all other cycles.
- R9: A grant with no eligible channel gives no valid output and changes no state.
- R10: outValid is high for exactly the cycle after a grant that found a winner, and outCh carries that winner.
- R11: Class encoding on cfgClass is 2'b00 low-delay and 2'b01 paced. 2'b10 and 2'b11 are both best-effort. A write with cfgWe takes effect from the next cycle; the grant in the same cycle still uses the old values.
- R12: Paced-time and due times wrap modulo 2^24. The due check uses a serial comparison of the 16-bit integer parts: a due time is reached when paced-time minus the due time, taken modulo 2^16, is below 2^15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Global slot strobe |
| cfgWe | input | 1 | Configuration write enable |
| cfgCh | input | CW | Channel written |
| cfgClass | input | 2 | Class for the written channel |
| cfgParam | input | TW | Rate parameter, 16.8 fixed point |
| ready | input | NUM_CH | Per-channel ready levels |
| resume | input | NUM_CH | Per-channel resume pulses |
| outValid | output | 1 | A winner was chosen on the previous grant |
| outCh | output | CW | ID of that winner |

## Verification
Some behaviours are checked by assertions on every cycle:
- a valid output follows a grant;
- a grant with nothing ready yields no valid output;
- a ready low-delay channel always takes the slot;
- paced-time moves only by one whole unit right after a grant;
- a resume loads the channel's due time with the paced-time from the cycle before.

Other behaviours only the bench scenarios can show:
- the order of winners that the due-time arithmetic produces;
- deferral of a rate change until the old due time;
- round-robin rotation;
- wrap-around of the 24-bit time base.

The bench compares every slot against an arithmetic model of these rules across directed phases, a random sweep and a run long enough to wrap paced-time.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    CLS_LOWDLY  = 2'b00,
    CLS_PACED   = 2'b01,
    CLS_BESTEFF = 2'b10,
    CLS_SPARE   = 2'b11
  } chClass_e;

  // strobes from arbitration to state
  typedef struct packed {
    logic fire;     // a winner exists on this grant
    logic advance;  // paced-time steps by one unit
    logic stepExp;  // winner's due time adds its rate
  } strobe_t;
endpackage

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IW     = 16,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          grant,
  input  logic [NUM_CH-1:0]             ready,
  input  logic [NUM_CH-1:0][1:0]        classVec,
  input  logic [NUM_CH-1:0][IW-1:0]     expInt,
  input  logic [IW-1:0]                 pacedInt,
  output strobe_t                       strobe,
  output logic [CW-1:0]                 winCh
);
  logic [CW-1:0] ldPtr, bePtr;
  logic [NUM_CH-1:0] ldReq, pcReq, beReq;
  logic [NUM_CH-1:0][IW-1:0] age;
  logic [CW:0] ldPick, bePick;
  logic pcFound;
  logic [CW-1:0] pcWin;
  logic [IW-1:0] bestAge;
  logic ldHit, beHit;

  function automatic logic [CW:0] rrPick(input logic [NUM_CH-1:0] req,
                                         input logic [CW-1:0] ptr);
    logic [CW:0] res;
    res = '0;
    for (int k = NUM_CH; k >= 1; k--) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_CH;
      if (req[idx]) res = {1'b1, CW'(idx)};
    end
    return res;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      age[i]   = pacedInt - expInt[i];
      ldReq[i] = ready[i] && (classVec[i] == CLS_LOWDLY);
      pcReq[i] = ready[i] && (classVec[i] == CLS_PACED) && !age[i][IW-1];
      beReq[i] = ready[i] && classVec[i][1];
    end
  end

  always_comb begin
    pcFound = 1'b0;
    pcWin   = '0;
    bestAge = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pcReq[i] && (!pcFound || age[i] > bestAge)) begin
        pcFound = 1'b1;
        pcWin   = CW'(i);
        bestAge = age[i];
      end
    end
  end

  assign ldPick = rrPick(ldReq, ldPtr);
  assign bePick = rrPick(beReq, bePtr);
  assign ldHit  = ldPick[CW];
  assign beHit  = bePick[CW];

  always_comb begin
    if (ldHit)        winCh = ldPick[CW-1:0];
    else if (pcFound) winCh = pcWin;
    else              winCh = bePick[CW-1:0];
    strobe.fire    = grant && (ldHit || pcFound || beHit);
    strobe.advance = grant && !ldHit && (pcFound || beHit);
    strobe.stepExp = grant && !ldHit && pcFound;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldPtr <= CW'(NUM_CH - 1);
      bePtr <= CW'(NUM_CH - 1);
    end else begin
      if (grant && ldHit) ldPtr <= winCh;
      if (grant && !ldHit && !pcFound && beHit) bePtr <= winCh;
    end
  end
endmodule

// File: rtl/pacer_dp.sv
module pacer_dp
  import pacer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TW     = 24,
  parameter int FW     = 8,
  localparam int CW    = $clog2(NUM_CH),
  localparam logic [TW-1:0] ONE = TW'(1) << FW
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [CW-1:0]             cfgCh,
  input  logic [1:0]                cfgClass,
  input  logic [TW-1:0]             cfgParam,
  input  logic [NUM_CH-1:0]         resume,
  input  strobe_t                   strobe,
  input  logic [CW-1:0]             winCh,
  output logic [NUM_CH-1:0][1:0]    classVec,
  output logic [NUM_CH-1:0][TW-1:0] expArr,
  output logic [TW-1:0]             pacedTime,
  output logic                      outValid,
  output logic [CW-1:0]             outCh
);
  logic [NUM_CH-1:0][TW-1:0] paramArr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pacedTime <= '0;
      outValid  <= 1'b0;
      outCh     <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        classVec[i] <= CLS_BESTEFF;
        paramArr[i] <= ONE;
        expArr[i]   <= '0;
      end
    end else begin
      outValid <= strobe.fire;
      if (strobe.fire) outCh <= winCh;
      if (strobe.advance) pacedTime <= pacedTime + ONE;
      for (int i = 0; i < NUM_CH; i++) begin
        if (resume[i])
          expArr[i] <= pacedTime;
        else if (strobe.stepExp && winCh == CW'(i))
          expArr[i] <= expArr[i] + paramArr[i];
        if (cfgWe && cfgCh == CW'(i)) begin
          classVec[i] <= cfgClass;
          paramArr[i] <= cfgParam;
        end
      end
    end
  end
endmodule

// File: rtl/pacer_sched.sv
module pacer_sched
  import pacer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TW     = 24,
  parameter int FW     = 8,
  localparam int CW    = $clog2(NUM_CH),
  localparam int IW    = TW - FW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grant,
  input  logic              cfgWe,
  input  logic [CW-1:0]     cfgCh,
  input  logic [1:0]        cfgClass,
  input  logic [TW-1:0]     cfgParam,
  input  logic [NUM_CH-1:0] ready,
  input  logic [NUM_CH-1:0] resume,
  output logic              outValid,
  output logic [CW-1:0]     outCh
);
  strobe_t                   strobe;
  logic [CW-1:0]             winCh;
  logic [NUM_CH-1:0][1:0]    classVec;
  logic [NUM_CH-1:0][TW-1:0] expArr;
  logic [NUM_CH-1:0][IW-1:0] expInt;
  logic [TW-1:0]             pacedTime;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_int
    assign expInt[g] = expArr[g][TW-1:FW];
  end

  pacer_ctrl #(.NUM_CH(NUM_CH), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .grant(grant), .ready(ready),
    .classVec(classVec), .expInt(expInt), .pacedInt(pacedTime[TW-1:FW]),
    .strobe(strobe), .winCh(winCh)
  );

  pacer_dp #(.NUM_CH(NUM_CH), .TW(TW), .FW(FW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgClass(cfgClass), .cfgParam(cfgParam), .resume(resume),
    .strobe(strobe), .winCh(winCh), .classVec(classVec),
    .expArr(expArr), .pacedTime(pacedTime),
    .outValid(outValid), .outCh(outCh)
  );
endmodule

// File: rtl/pacer_sched_chk.sv
module pacer_sched_chk #(
  parameter int NUM_CH = 8,
  parameter int TW     = 24,
  parameter int FW     = 8,
  localparam int CW    = $clog2(NUM_CH),
  localparam logic [TW-1:0] ONE = TW'(1) << FW
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      grant,
  input logic [NUM_CH-1:0]         ready,
  input logic [NUM_CH-1:0]         resume,
  input logic                      outValid,
  input logic [CW-1:0]             outCh,
  input logic [TW-1:0]             pacedTime,
  input logic [NUM_CH-1:0][TW-1:0] expArr,
  input logic [NUM_CH-1:0][1:0]    classVec
);
  logic [NUM_CH-1:0]      ldReady;
  logic [NUM_CH-1:0][1:0] classQ;

  always_comb
    for (int i = 0; i < NUM_CH; i++) ldReady[i] = ready[i] && (classVec[i] == 2'b00);

  always_ff @(posedge clk) classQ <= classVec;

  // R10
  valid_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(grant));

  // R9
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant && ready == '0) |=> !outValid);

  // R2
  lowdly_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant && |ldReady) |=> (outValid && classQ[outCh] == 2'b00));

  // R8
  time_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pacedTime != $past(pacedTime)) |->
      ($past(grant) && pacedTime == TW'($past(pacedTime) + ONE)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    // R7
    resume_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      resume[g] |=> (expArr[g] == $past(pacedTime)));
  end
endmodule

bind pacer_sched pacer_sched_chk #(.NUM_CH(NUM_CH), .TW(TW), .FW(FW)) u_chk (
  .clk(clk), .rstN(rstN), .grant(grant), .ready(ready), .resume(resume),
  .outValid(outValid), .outCh(outCh), .pacedTime(pacedTime),
  .expArr(expArr), .classVec(classVec)
);

// File: tb/pacer_sched_tb.sv
`timescale 1ns/1ps
module pacer_sched_tb;
  localparam int N  = 8;
  localparam int CW = 3;
  localparam int TW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grant = 1'b0, cfgWe = 1'b0;
  logic [CW-1:0] cfgCh = '0;
  logic [1:0] cfgClass = '0;
  logic [TW-1:0] cfgParam = '0;
  logic [N-1:0] ready = '0, resume = '0;
  logic outValid;
  logic [CW-1:0] outCh;

  int checks = 0, fails = 0;
  int mCls[N], mPar[N], mExp[N];
  int mPt, mLd, mBe;

  always #4 clk = ~clk;

  pacer_sched u_dut (
    .clk(clk), .rstN(rstN), .grant(grant), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgClass(cfgClass), .cfgParam(cfgParam), .ready(ready), .resume(resume),
    .outValid(outValid), .outCh(outCh)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic step(input bit g, input logic [N-1:0] rdy, input logic [N-1:0] rs,
                      input bit we, input int wch, input int wcls, input int wpar,
                      input string tag);
    int w, wc, bestAge, oldPt;
    string t;
    grant = g; ready = rdy; resume = rs; cfgWe = we;
    cfgCh = CW'(wch); cfgClass = 2'(wcls); cfgParam = TW'(wpar);
    w = -1; wc = -1; bestAge = -1; oldPt = mPt;
    for (int k = 1; k <= N; k++) begin
      int idx = (mLd + k) % N;
      if (w < 0 && rdy[idx] && mCls[idx] == 0) begin w = idx; wc = 0; end
    end
    if (w < 0)
      for (int i = 0; i < N; i++) begin
        int a = ((mPt >> 8) - (mExp[i] >> 8)) & 16'hFFFF;
        if (rdy[i] && mCls[i] == 1 && a < 32768 && a > bestAge) begin
          w = i; wc = 1; bestAge = a;
        end
      end
    if (w < 0)
      for (int k = 1; k <= N; k++) begin
        int idx = (mBe + k) % N;
        if (w < 0 && rdy[idx] && mCls[idx] >= 2) begin w = idx; wc = 2; end
      end
    if (g && w >= 0) begin
      if (wc == 0) mLd = w;
      else begin
        mPt = (mPt + 256) & 24'hFFFFFF;
        if (wc == 1) mExp[w] = (mExp[w] + mPar[w]) & 24'hFFFFFF;
        else mBe = w;
      end
    end
    for (int i = 0; i < N; i++) if (rs[i]) mExp[i] = oldPt;
    if (we) begin mCls[wch] = wcls; mPar[wch] = wpar; end
    @(negedge clk);
    if (tag != "") t = tag;
    else if (!g || w < 0) t = "R9";
    else if (wc == 0) t = "R2";
    else if (wc == 1) t = "R4";
    else t = "R3";
    chk(outValid == (g && w >= 0), {t, " valid"}, int'(outValid), int'(g && w >= 0));
    if (g && w >= 0) chk(int'(outCh) == w, {t, " channel"}, int'(outCh), w);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mCls[i] = 2; mPar[i] = 256; mExp[i] = 0; end
    mPt = 0; mLd = N - 1; mBe = N - 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 reset valid", int'(outValid), 0);

    // R9: nothing ready
    step(1, 8'h00, 0, 0, 0, 0, 0, "R9");
    // R1: all best-effort after reset, search starts at channel 0
    step(1, 8'hFF, 0, 0, 0, 0, 0, "R1");
    step(1, 8'hFF, 0, 0, 0, 0, 0, "R1");

    // R11: ch2 paced rate 2.0, ch0 and ch1 low-delay, ch5 class 3
    step(0, 0, 0, 1, 2, 1, 32'h200, "R11");
    step(0, 0, 0, 1, 0, 0, 32'h100, "R11");
    step(0, 0, 0, 1, 1, 0, 32'h100, "R11");
    step(0, 0, 0, 1, 5, 3, 32'h100, "R11");

    // R5: paced every other slot against best-effort
    for (int s = 0; s < 8; s++) step(1, 8'h24, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    // R2/R3: low-delay rotation over paced and best-effort
    for (int s = 0; s < 4; s++) step(1, 8'h27, 0, 0, 0, 0, 0, "R3");
    // R8: low-delay wins leave time still, then paced resumes its cadence
    for (int s = 0; s < 4; s++) step(1, 8'h01, 0, 0, 0, 0, 0, "R8");
    for (int s = 0; s < 4; s++) step(1, 8'h24, 0, 0, 0, 0, 0, "R8");

    // R6: rate change waits for the already scheduled due time
    step(0, 0, 0, 1, 2, 1, 32'h800, "R6");
    for (int s = 0; s < 14; s++) step(1, 8'h24, 0, 0, 0, 0, 0, "R6");
    // R7: resume makes ch2 due now
    step(0, 0, 0, 1, 2, 1, 32'h100, "R7");
    step(0, 8'h24, 8'h04, 0, 0, 0, 0, "R7");
    step(1, 8'h24, 0, 0, 0, 0, 0, "R7");
    for (int s = 0; s < 4; s++) step(1, 8'h24, 0, 0, 0, 0, 0, "R7");

    // R4: ties to lowest ID, earliest due first
    step(0, 0, 0, 1, 6, 1, 32'h180, "R4");
    step(0, 0, 0, 1, 3, 1, 32'h300, "R4");
    step(0, 0, 8'h48, 0, 0, 0, 0, "R4");
    for (int s = 0; s < 12; s++) step(1, 8'h6C, 0, 0, 0, 0, 0, "R4");

    // random sweep over classes, rates, ready, resume and writes
    for (int s = 0; s < 4000; s++) begin
      bit g = ($urandom % 4) != 0;
      bit we = ($urandom % 8) == 0;
      logic [N-1:0] rs = (($urandom % 16) == 0) ? N'($urandom) : '0;
      step(g, N'($urandom), rs, we, $urandom % N, $urandom % 4,
           ($urandom % 1024), "");
    end

    // R12: wrap paced-time past 2^24 with ch3 paced and ch4 best-effort
    for (int i = 0; i < N; i++) step(0, 0, 0, 1, i, 2, 32'h100, "R11");
    step(0, 0, 0, 1, 3, 1, 32'h300, "R12");
    step(0, 0, 8'h08, 0, 0, 0, 0, "R12");
    for (int s = 0; s < 67000; s++) step(1, 8'h18, 0, 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    summary();
  end
endmodule